// File: doc/BRIEF.md
# Synchronous Buck Gate Command Sequencer

This block turns a digital duty request into the two gate commands of a synchronous step-down power stage. A free-running counter divides the system clock into fixed switching periods and stands in for the modulator ramp. The duty word is sampled once per period. The high-side command is requested from the start of the period and drops once the counter reaches the duty count, which is trailing-edge modulation. The low-side command fills the rest of the period. A programmable dead time separates each falling gate from the rising one, so the two commands never overlap.

Three rules shape the waveform beyond plain modulation:
- **Bootstrap refresh.** A run of back-to-back full-duty periods is capped. The period after the cap has its high-side pulse cut at mid-period, which forces a low-side pulse that recharges the bootstrap capacitor.
- **Minimum pulse.** Very short nonzero requests are stretched to a minimum on-time.
- **Pre-biased start-up.** The low-side switch is held off after reset or after a disable until the high side has actually switched on or a soft-start-progress flag is seen. This keeps the stage from discharging a pre-charged output.

A disable input from the fault sequencer forces both gates low in the same cycle and re-arms that start-up rule.

Top module: `buck_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the period logic requests otherwise, both gate outputs are low. The period counter starts at zero, so the first period after reset has a duty of zero.
- R2: A switching period lasts PERIOD clocks (64 by default). The duty word is sampled in the last clock of a period and governs the whole next period.
- R3: For a duty d with MIN_ON <= d < PERIOD, in a period that follows one ending with the low side on, the high-side gate is high for d-DEAD clocks and the low-side gate is high for PERIOD-d-DEAD clocks. With the defaults (DEAD=2), d=20 gives 18/42 and d=40 gives 38/22.
- R4: The two gates are never high in the same cycle. Each gate rises only after the other has been low for DEAD clocks.
- R5: A nonzero duty below MIN_ON (6 by default) acts as MIN_ON, so with the defaults the high side is on for 4 clocks. A duty of zero keeps the high side off for the whole period.
- R6: A duty of PERIOD or more requests full on. The high-side gate stays high across period boundaries between consecutive full-on periods.
- R7: After FULL_LIMIT (20 by default) consecutive full-on periods, the next full-on period has its high-side pulse ended at PERIOD/2. The low side is then on for PERIOD/2-DEAD clocks, and the consecutive count starts again from zero.
- R8: Any period whose request is not full-on clears the consecutive full-on count.
- R9: After reset or a disable, the low-side gate stays low until either the high-side gate has been high or the soft-start flag has been seen high.
- R10: While disable is high, both gate outputs are low in the same cycle. The next cycle still shows them low. Disable re-arms R9 and clears the R7 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | DUTY_W | Requested high-side on-time in clocks per period |
| ss_ok_i | input | 1 | Soft start has passed its threshold |
| disable_i | input | 1 | Fault sequencer forces both switches off |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |

## Verification
The bench records, for every switching period, how many clocks each gate was high, and compares those counts with values derived from the requirements.

Each pattern distinguishes a different fault:
- **Steady mid-range duties** expose errors in dead time or period length.
- **Tiny duties** separate the stretch-to-minimum behaviour from skipping.
- **A zero duty** with and without the soft-start flag shows whether the start-up hold works.
- **A run of 21 full-on periods** locates the forced mid-period cut in exactly the right period.
- **A full-on run broken by one partial period** shows whether the count is cleared.
- **A disable in mid-pulse, followed by a zero-duty then small-duty request,** proves that the first high-side attempt, and nothing before it, releases the low side.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

    // Classification of one switching period, decided at its start.
    typedef enum logic [1:0] {
        PK_IDLE,
        PK_PARTIAL,
        PK_FULL,
        PK_FORCED
    } period_kind_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // Number of clocks at the start of the period during which the
    // high side is requested.
    function automatic int unsigned on_length(
        input period_kind_t kind,
        input int unsigned  duty,
        input int unsigned  min_on,
        input int unsigned  period
    );
        case (kind)
            PK_IDLE:    return 0;
            PK_PARTIAL: return (duty < min_on) ? min_on : duty;
            PK_FULL:    return period;
            default:    return period / 2;
        endcase
    endfunction

endpackage

// File: rtl/bgc_period_timer.sv
module bgc_period_timer #(
    parameter int unsigned PERIOD = 64,
    parameter int unsigned CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == CW'(PERIOD - 1));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (last_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bgc_modulator.sv
module bgc_modulator
    import buck_gate_pkg::*;
#(
    parameter int unsigned PERIOD     = 64,
    parameter int unsigned CW         = $clog2(PERIOD),
    parameter int unsigned DUTY_W     = $clog2(PERIOD) + 1,
    parameter int unsigned MIN_ON     = 6,
    parameter int unsigned FULL_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disable_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              last_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              demand_o
);
    localparam int unsigned FW = $clog2(FULL_LIMIT + 1);

    logic [DUTY_W-1:0] duty_q;
    logic [FW-1:0]     full_run_q;
    period_kind_t      kind;
    int unsigned       on_len;

    always_comb begin
        if (duty_q == '0)
            kind = PK_IDLE;
        else if (32'(duty_q) >= PERIOD)
            kind = (full_run_q == FW'(FULL_LIMIT)) ? PK_FORCED : PK_FULL;
        else
            kind = PK_PARTIAL;
    end

    assign on_len   = on_length(kind, 32'(duty_q), MIN_ON, PERIOD);
    assign demand_o = (32'(cnt_i) < on_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q     <= '0;
            full_run_q <= '0;
        end else begin
            if (last_i)
                duty_q <= duty_i;
            if (disable_i)
                full_run_q <= '0;
            else if (last_i)
                full_run_q <= (kind == PK_FULL) ? full_run_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/bgc_gate_seq.sv
module bgc_gate_seq
    import buck_gate_pkg::*;
#(
    parameter int unsigned DEAD = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       disable_i,
    input  logic       ss_ok_i,
    input  logic       demand_i,
    output gate_pair_t gates_o
);
    localparam int unsigned GW = $clog2(DEAD + 1);

    gate_pair_t    q;
    logic [GW-1:0] hs_low_q;
    logic [GW-1:0] ls_low_q;
    logic          armed_q;
    logic          hs_nxt;
    logic          ls_nxt;

    assign hs_nxt = demand_i && !q.ls && (ls_low_q >= GW'(DEAD - 1));
    assign ls_nxt = !demand_i && armed_q && !q.hs && (hs_low_q >= GW'(DEAD - 1));
    assign gates_o = q;

    always_ff @(posedge clk) begin
        if (rst || disable_i) begin
            q        <= '0;
            armed_q  <= 1'b0;
            hs_low_q <= GW'(DEAD);
            ls_low_q <= GW'(DEAD);
        end else begin
            q.hs     <= hs_nxt;
            q.ls     <= ls_nxt;
            armed_q  <= armed_q || q.hs || ss_ok_i;
            hs_low_q <= q.hs ? '0 : ((hs_low_q == GW'(DEAD)) ? hs_low_q : hs_low_q + 1'b1);
            ls_low_q <= q.ls ? '0 : ((ls_low_q == GW'(DEAD)) ? ls_low_q : ls_low_q + 1'b1);
        end
    end
endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
    import buck_gate_pkg::*;
#(
    parameter int unsigned PERIOD     = 64,
    parameter int unsigned DUTY_W     = $clog2(PERIOD) + 1,
    parameter int unsigned MIN_ON     = 6,
    parameter int unsigned DEAD       = 2,
    parameter int unsigned FULL_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ss_ok_i,
    input  logic              disable_i,
    output logic              hs_gate_o,
    output logic              ls_gate_o
);
    localparam int unsigned CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          last;
    logic          demand;
    gate_pair_t    gates;

    bgc_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .last_o (last)
    );

    bgc_modulator #(
        .PERIOD     (PERIOD),
        .CW         (CW),
        .DUTY_W     (DUTY_W),
        .MIN_ON     (MIN_ON),
        .FULL_LIMIT (FULL_LIMIT)
    ) u_mod (
        .clk       (clk),
        .rst       (rst),
        .disable_i (disable_i),
        .cnt_i     (cnt),
        .last_i    (last),
        .duty_i    (duty_i),
        .demand_o  (demand)
    );

    bgc_gate_seq #(.DEAD(DEAD)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .disable_i (disable_i),
        .ss_ok_i   (ss_ok_i),
        .demand_i  (demand),
        .gates_o   (gates)
    );

    assign hs_gate_o = gates.hs && !disable_i;
    assign ls_gate_o = gates.ls && !disable_i;
endmodule

// File: rtl/buck_gate_ctrl_checker.sv
module buck_gate_ctrl_checker #(
    parameter int unsigned PERIOD     = 64,
    parameter int unsigned DEAD       = 2,
    parameter int unsigned FULL_LIMIT = 20
) (
    input logic clk,
    input logic rst,
    input logic ss_ok_i,
    input logic disable_i,
    input logic hs_gate_o,
    input logic ls_gate_o
);
    localparam int unsigned MAX_RUN = (FULL_LIMIT + 1) * PERIOD;

    int unsigned hs_off_run;
    int unsigned ls_off_run;
    int unsigned hs_on_run;
    logic        armed_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_off_run <= DEAD;
            ls_off_run <= DEAD;
            hs_on_run  <= 0;
            armed_m    <= 1'b0;
        end else begin
            hs_off_run <= hs_gate_o ? 0 : ((hs_off_run >= DEAD) ? DEAD : hs_off_run + 1);
            ls_off_run <= ls_gate_o ? 0 : ((ls_off_run >= DEAD) ? DEAD : ls_off_run + 1);
            hs_on_run  <= hs_gate_o ? hs_on_run + 1 : 0;
            armed_m    <= disable_i ? 1'b0 : (armed_m || hs_gate_o || ss_ok_i);
        end
    end

    // R4: no overlap of the two gates
    a_r4_never_both: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate_o && ls_gate_o));

    // R4: low side rises only after high side low for DEAD clocks
    a_r4_ls_dead: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_gate_o) |-> (hs_off_run >= DEAD));

    // R4: high side rises only after low side low for DEAD clocks
    a_r4_hs_dead: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate_o) |-> (ls_off_run >= DEAD));

    // R9: low side needs a prior high-side attempt or soft-start flag
    a_r9_ls_needs_arm: assert property (@(posedge clk) disable iff (rst)
        ls_gate_o |-> armed_m);

    // R10: gates stay low in the cycle after a disable
    a_r10_disable_low: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> (!hs_gate_o && !ls_gate_o));

    // R7: continuous high-side run is bounded
    a_r7_full_run_bounded: assert property (@(posedge clk) disable iff (rst)
        hs_on_run < MAX_RUN);
endmodule

bind buck_gate_ctrl buck_gate_ctrl_checker #(
    .PERIOD     (PERIOD),
    .DEAD       (DEAD),
    .FULL_LIMIT (FULL_LIMIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ss_ok_i   (ss_ok_i),
    .disable_i (disable_i),
    .hs_gate_o (hs_gate_o),
    .ls_gate_o (ls_gate_o)
);

// File: tb/test_buck_gate_ctrl.sv
module test_buck_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 64;
    localparam int DW         = 7;
    localparam int MINON      = 6;
    localparam int DT         = 2;
    localparam int LIM        = 20;
    localparam int MAXP       = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] duty = '0;
    logic          ss_ok = 1'b0;
    logic          dis = 1'b0;
    logic          hs;
    logic          ls;

    int n = 0;
    int sched   [MAXP];
    int hs_hist [MAXP];
    int ls_hist [MAXP];
    int acc_hs = 0;
    int acc_ls = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    buck_gate_ctrl #(
        .PERIOD(P), .DUTY_W(DW), .MIN_ON(MINON), .DEAD(DT), .FULL_LIMIT(LIM)
    ) i_buck_gate_ctrl (
        .clk(clk), .rst(rst), .duty_i(duty), .ss_ok_i(ss_ok),
        .disable_i(dis), .hs_gate_o(hs), .ls_gate_o(ls)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    // Per-period gate-high counts and duty driver, away from the edge.
    always @(negedge clk) begin
        if (!rst && n >= 1) begin
            acc_hs = acc_hs + int'(hs);
            acc_ls = acc_ls + int'(ls);
            if (n % P == 0 && n / P - 1 < MAXP) begin
                hs_hist[n / P - 1] = acc_hs;
                ls_hist[n / P - 1] = acc_ls;
                acc_hs = 0;
                acc_ls = 0;
            end
        end
        if (!rst && (n % P) == P - 1 && (n + 1) / P < MAXP)
            duty = DW'(sched[(n + 1) / P]);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int from, input int val);
        for (int k = from; k < MAXP; k++) sched[k] = val;
    endtask

    task automatic wait_hist(input int k);
        while (n < (k + 1) * P + 1) @(negedge clk);
    endtask

    task automatic next_start(output int s);
        s = n / P + 2;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1", "hs in reset", int'(hs), 0);
        chk("R1", "ls in reset", int'(ls), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "hs after reset", int'(hs), 0);
        chk("R9", "ls after reset unarmed", int'(ls), 0);
    endtask

    task automatic t_unarmed_idle();
        int s;
        next_start(s);
        fill(s, 0);
        wait_hist(s + 1);
        chk("R9", "ls idle unarmed", ls_hist[s + 1], 0);
        chk("R5", "hs zero duty", hs_hist[s + 1], 0);
    endtask

    task automatic t_softstart_arm();
        int s;
        ss_ok = 1'b1;
        s = n / P + 1;
        wait_hist(s);
        chk("R9", "ls after soft-start flag", ls_hist[s], P);
        chk("R5", "hs zero duty armed", hs_hist[s], 0);
    endtask

    task automatic t_partial();
        int s;
        next_start(s);
        sched[s] = 20; sched[s + 1] = 20; fill(s + 2, 40);
        wait_hist(s + 2);
        chk("R3", "hs d=20", hs_hist[s], 20 - DT);
        chk("R3", "ls d=20", ls_hist[s], P - 20 - DT);
        chk("R2", "hs d=20 repeat", hs_hist[s + 1], 20 - DT);
        chk("R3", "hs d=40", hs_hist[s + 2], 40 - DT);
        chk("R3", "ls d=40", ls_hist[s + 2], P - 40 - DT);
    endtask

    task automatic t_min_on();
        int s;
        next_start(s);
        sched[s] = 1; sched[s + 1] = MINON; fill(s + 2, 0);
        wait_hist(s + 2);
        chk("R5", "hs d=1 stretched", hs_hist[s], MINON - DT);
        chk("R5", "ls d=1", ls_hist[s], P - MINON - DT);
        chk("R5", "hs d=MIN_ON", hs_hist[s + 1], MINON - DT);
        chk("R5", "hs d=0", hs_hist[s + 2], 0);
        chk("R5", "ls d=0", ls_hist[s + 2], P);
    endtask

    task automatic t_full_limit();
        int s;
        int bad;
        next_start(s);
        for (int k = 0; k < LIM + 2; k++) sched[s + k] = P;
        fill(s + LIM + 2, 20);
        wait_hist(s + LIM + 2);
        chk("R6", "hs first full", hs_hist[s], P - DT);
        chk("R6", "ls first full", ls_hist[s], 0);
        bad = 0;
        for (int k = 1; k < LIM; k++)
            if (hs_hist[s + k] != P || ls_hist[s + k] != 0) bad++;
        chk("R6", "full periods 2..20 not all on", bad, 0);
        chk("R7", "hs forced period", hs_hist[s + LIM], P / 2);
        chk("R7", "ls forced period", ls_hist[s + LIM], P / 2 - DT);
        chk("R7", "hs after forced", hs_hist[s + LIM + 1], P - DT);
        chk("R6", "hs partial after full", hs_hist[s + LIM + 2], 20);
        chk("R3", "ls partial after full", ls_hist[s + LIM + 2], P - 20 - DT);
    endtask

    task automatic t_count_clear();
        int s;
        next_start(s);
        for (int k = 0; k < 15; k++) sched[s + k] = P;
        sched[s + 15] = 20;
        for (int k = 16; k < 22; k++) sched[s + k] = P;
        fill(s + 22, 20);
        wait_hist(s + 21);
        chk("R8", "hs 6th full after break", hs_hist[s + 21], P);
        chk("R8", "ls 6th full after break", ls_hist[s + 21], 0);
    endtask

    task automatic t_disable();
        int s;
        int bad;
        while (n % P != 5) @(negedge clk);
        dis = 1'b1;
        #1;
        chk("R10", "hs same cycle", int'(hs), 0);
        chk("R10", "ls same cycle", int'(ls), 0);
        fill(n / P + 1, 0);
        ss_ok = 1'b0;
        bad = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (hs || ls) bad++;
        end
        chk("R10", "gates while disabled", bad, 0);
        while (n % P != 30) @(negedge clk);
        dis = 1'b0;
        s = n / P + 1;
        fill(s + 2, 10);
        wait_hist(s + 3);
        chk("R10", "ls re-armed hold p1", ls_hist[s], 0);
        chk("R9", "ls re-armed hold p2", ls_hist[s + 1], 0);
        chk("R9", "hs first attempt", hs_hist[s + 2], 10);
        chk("R9", "ls after hs attempt", ls_hist[s + 2], P - 10 - DT);
        chk("R3", "hs d=10 steady", hs_hist[s + 3], 10 - DT);
    endtask

    initial begin
        for (int k = 0; k < MAXP; k++) begin
            sched[k] = 0; hs_hist[k] = -1; ls_hist[k] = -1;
        end
        t_reset();
        t_unarmed_idle();
        t_softstart_arm();
        t_partial();
        t_min_on();
        t_full_limit();
        t_count_clear();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule